// File: doc/BRIEF.md
# Switchable-Length Rate-1/2 Convolutional Encoder

This block turns a serial bit stream into pairs of coded symbols for a forward error correction link. It runs on the system clock and accepts one data bit on each cycle where the bit strobe is high. For every accepted bit it produces one symbol pair, G1 and G2, from a nine-place history of past bits. Two code families share that history: a short code that uses only the seven newest places and a long code that uses all nine. A select input picks the family at run time.

Two optional transforms wrap the coding core. Before coding, a differential stage can replace each bit with its XOR against the previous bit that entered the history. After coding, the G2 symbol can be inverted as a simple scrambling step. The block feeds a modulator: the modulator reads `sym_g1`/`sym_g2` once per strobe, two strobes after the matching bit was accepted.

Top module: `conv_enc_top`

## Requirements
- R1: On each clock edge with `bit_en` high, the differentially processed bit enters history place 0 (newest), and places 0..7 move to places 1..8. A place index is the number of strobes since that bit entered.
- R2: With `long_k_sel` low, G1 uses generator 171 octal and G2 uses 133 octal over places 0..6. The generator's most significant of its 7 bits taps place 0 and its least significant bit taps place 6. A symbol is the XOR of the tapped places.
- R3: With `long_k_sel` high, G1 uses generator 753 octal and G2 uses 561 octal over places 0..8. The most significant of the 9 bits taps place 0.
- R4: A bit accepted at strobe edge n sets the symbol pair seen on the outputs after strobe edge n+2. The pair holds until edge n+3. The length select is sampled at edge n+1 and the inversion control at edge n+2.
- R5: With `g2_inv_en` high at the output edge, `sym_g2` is the complement of the coded G2 and `sym_g1` is the uncoded-by-inversion G1.
- R6: With `diff_en` high, the bit entering the history is `din` XOR the bit that entered before it. With `diff_en` low it is `din`. The remembered previous bit is 0 after reset.
- R7: A change of `long_k_sel` keeps the history. The next coded pair uses the new generators over the existing places.
- R8: While `bit_en` is low, the history, the differential state and both outputs keep their values, whatever the other inputs do.
- R9: A low `rst_n` at once clears the history, the differential state and both outputs to 0. The release of the reset is synchronized and takes effect at the second clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Data strobe: accept `din` on this edge |
| din | input | 1 | Serial data bit |
| long_k_sel | input | 1 | 0: length-7 generators, 1: length-9 generators |
| diff_en | input | 1 | Enable differential processing before coding |
| g2_inv_en | input | 1 | Invert the G2 symbol after coding |
| sym_g1 | output | 1 | Coded symbol G1 |
| sym_g2 | output | 1 | Coded symbol G2 |

## Verification
A wrong history place or a dropped bit corrupts the symbol stream two strobes later. It stays visible for as many strobes as the generator reaches back, so up to nine pairs show it. A wrong differential state flips every following coded bit in the stream, so the divergence shows at the next symbol pair and grows from there. Impulse responses compared against the generator digits, a length switch in mid-stream, and idle periods with changing inputs cover the places where the tap mapping and the enables could go wrong.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

  localparam int unsigned CENC_SHORT_K = 7;
  localparam int unsigned CENC_LONG_K  = 9;

  // Map a generator written MSB-first onto history places (place 0 = newest).
  function automatic logic [31:0] delay_mask(input logic [31:0] gen, input int unsigned k);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < k) m[i] = gen[k - 1 - i];
    end
    return m;
  endfunction

endpackage

// File: rtl/cenc_diff_stage.sv
module cenc_diff_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic enable,
  input  logic bit_in,
  output logic bit_out
);
  logic state_q;
  logic state_d;

  always_comb begin
    bit_out = bit_in ^ (enable & state_q);
    state_d = state_q;
    if (step) state_d = bit_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/cenc_code_core.sv
module cenc_code_core #(
  parameter int unsigned       SR_W        = 9,
  parameter logic [2*SR_W-1:0] MASKS_SHORT = '0,
  parameter logic [2*SR_W-1:0] MASKS_LONG  = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       bit_in,
  input  logic       long_sel,
  output logic [1:0] raw_sym
);
  logic [SR_W-1:0] hist_q;
  logic [SR_W-1:0] hist_d;
  logic [1:0]      code_d;
  logic [1:0]      raw_d;

  always_comb begin
    hist_d = hist_q;
    if (step) hist_d = {hist_q[SR_W-2:0], bit_in};
  end

  for (genvar s = 0; s < 2; s++) begin : g_sym
    logic [SR_W-1:0] mask;
    assign mask      = long_sel ? MASKS_LONG[s*SR_W +: SR_W] : MASKS_SHORT[s*SR_W +: SR_W];
    assign code_d[s] = ^(hist_q & mask);
  end

  always_comb begin
    raw_d = raw_sym;
    if (step) raw_d = code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      raw_sym <= '0;
    end else begin
      hist_q  <= hist_d;
      raw_sym <= raw_d;
    end
  end
endmodule

// File: rtl/cenc_out_stage.sv
module cenc_out_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [1:0] raw_sym,
  input  logic       inv_g2,
  output logic       g1_q,
  output logic       g2_q
);
  logic g1_d;
  logic g2_d;

  always_comb begin
    g1_d = g1_q;
    g2_d = g2_q;
    if (step) begin
      g1_d = raw_sym[0];
      g2_d = raw_sym[1] ^ inv_g2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= 1'b0;
      g2_q <= 1'b0;
    end else begin
      g1_q <= g1_d;
      g2_q <= g2_d;
    end
  end
endmodule

// File: rtl/conv_enc_top.sv
module conv_enc_top
  import conv_enc_pkg::*;
#(
  parameter int unsigned SHORT_K = CENC_SHORT_K,
  parameter int unsigned LONG_K  = CENC_LONG_K,
  parameter logic [31:0] GEN_S1  = 32'o171,
  parameter logic [31:0] GEN_S2  = 32'o133,
  parameter logic [31:0] GEN_L1  = 32'o753,
  parameter logic [31:0] GEN_L2  = 32'o561
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic din,
  input  logic long_k_sel,
  input  logic diff_en,
  input  logic g2_inv_en,
  output logic sym_g1,
  output logic sym_g2
);
  localparam int unsigned SR_W = LONG_K;
  localparam logic [SR_W-1:0] M_S1 = SR_W'(delay_mask(GEN_S1, SHORT_K));
  localparam logic [SR_W-1:0] M_S2 = SR_W'(delay_mask(GEN_S2, SHORT_K));
  localparam logic [SR_W-1:0] M_L1 = SR_W'(delay_mask(GEN_L1, LONG_K));
  localparam logic [SR_W-1:0] M_L2 = SR_W'(delay_mask(GEN_L2, LONG_K));

  logic       rst_meta;
  logic       rst_q;
  logic       coded_bit;
  logic [1:0] raw_sym;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  cenc_diff_stage u_diff (
    .clk    (clk),
    .rst_n  (rst_q),
    .step   (bit_en),
    .enable (diff_en),
    .bit_in (din),
    .bit_out(coded_bit)
  );

  cenc_code_core #(
    .SR_W       (SR_W),
    .MASKS_SHORT({M_S2, M_S1}),
    .MASKS_LONG ({M_L2, M_L1})
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_q),
    .step    (bit_en),
    .bit_in  (coded_bit),
    .long_sel(long_k_sel),
    .raw_sym (raw_sym)
  );

  cenc_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_q),
    .step   (bit_en),
    .raw_sym(raw_sym),
    .inv_g2 (g2_inv_en),
    .g1_q   (sym_g1),
    .g2_q   (sym_g2)
  );
endmodule

// File: rtl/conv_enc_checker.sv
module conv_enc_checker #(
  parameter int unsigned SR_W = 9
) (
  input logic            clk,
  input logic            rst_q,
  input logic            bit_en,
  input logic            din,
  input logic            diff_en,
  input logic [SR_W-1:0] hist,
  input logic            dstate,
  input logic [1:0]      raw_sym,
  input logic            sym_g1,
  input logic            sym_g2
);
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_q)
    bit_en |=> hist[SR_W-1:1] == $past(hist[SR_W-2:0]));

  p_entry_r6: assert property (@(posedge clk) disable iff (!rst_q)
    bit_en |=> hist[0] == dstate);

  p_plain_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (bit_en && !diff_en) |=> dstate == $past(din));

  p_g1_clean_r5: assert property (@(posedge clk) disable iff (!rst_q)
    bit_en |=> sym_g1 == $past(raw_sym[0]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !bit_en |=> ($stable(sym_g1) && $stable(sym_g2) && $stable(hist) && $stable(dstate)));
endmodule

bind conv_enc_top conv_enc_checker #(.SR_W(SR_W)) u_chk (
  .clk    (clk),
  .rst_q  (rst_q),
  .bit_en (bit_en),
  .din    (din),
  .diff_en(diff_en),
  .hist   (u_core.hist_q),
  .dstate (u_diff.state_q),
  .raw_sym(raw_sym),
  .sym_g1 (sym_g1),
  .sym_g2 (sym_g2)
);

// File: tb/test_conv_enc_top.sv
module test_conv_enc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic din = 1'b0;
  logic long_k_sel = 1'b0;
  logic diff_en = 1'b0;
  logic g2_inv_en = 1'b0;
  logic sym_g1;
  logic sym_g2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [8:0] m_hist;
  logic       m_prev;
  logic       m_raw1, m_raw2;
  logic       m_e1, m_e2;

  always #5 clk = ~clk;

  conv_enc_top i_conv_enc_top (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
    .long_k_sel(long_k_sel), .diff_en(diff_en), .g2_inv_en(g2_inv_en),
    .sym_g1(sym_g1), .sym_g2(sym_g2)
  );

  // vectors {g2_inv_en, diff_en, long_k_sel, din}
  localparam int NV = 40;
  localparam logic [3:0] VEC [NV] = '{
    4'b0001, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0000,
    4'b0011, 4'b0010, 4'b0011, 4'b0011, 4'b0011, 4'b0010, 4'b0010, 4'b0011,
    4'b1001, 4'b1000, 4'b1001, 4'b1011, 4'b1010, 4'b1011, 4'b1000, 4'b1001,
    4'b0101, 4'b0101, 4'b0100, 4'b0101, 4'b0111, 4'b0110, 4'b0111, 4'b0111,
    4'b1101, 4'b1111, 4'b1110, 4'b1100, 4'b1101, 4'b0001, 4'b0010, 4'b0011
  };

  localparam logic [6:0] IMP7_G1 = 7'b1111001; // 171 octal
  localparam logic [6:0] IMP7_G2 = 7'b1011011; // 133 octal
  localparam logic [8:0] IMP9_G1 = 9'b111101011; // 753 octal
  localparam logic [8:0] IMP9_G2 = 9'b101110001; // 561 octal

  function automatic logic parity_of(input logic [8:0] h, input logic [8:0] gen, input int k);
    logic x;
    x = 1'b0;
    for (int i = 0; i < k; i++) if (gen[k-1-i]) x ^= h[i];
    return x;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hist = '0; m_prev = 1'b0; m_raw1 = 1'b0; m_raw2 = 1'b0; m_e1 = 1'b0; m_e2 = 1'b0;
  endtask

  task automatic model_step(input logic b, input logic lk, input logic de, input logic iv);
    logic d;
    m_e1 = m_raw1;
    m_e2 = m_raw2 ^ iv;
    if (lk) begin
      m_raw1 = parity_of(m_hist, 9'o753, 9);
      m_raw2 = parity_of(m_hist, 9'o561, 9);
    end else begin
      m_raw1 = parity_of(m_hist, 9'o171, 7);
      m_raw2 = parity_of(m_hist, 9'o133, 7);
    end
    d = de ? (b ^ m_prev) : b;
    m_prev = d;
    m_hist = {m_hist[7:0], d};
  endtask

  // drive at a falling edge, strobe one rising edge, sample at the next falling edge
  task automatic step(input logic b, input logic lk, input logic de, input logic iv);
    din = b; long_k_sel = lk; diff_en = de; g2_inv_en = iv; bit_en = 1'b1;
    @(posedge clk);
    model_step(b, lk, de, iv);
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b0;
    #1;
    check("R9 reset g1", sym_g1, 1'b0);
    check("R9 reset g2", sym_g2, 1'b0);
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 after release g1", sym_g1, 1'b0);
    check("R9 after release g2", sym_g2, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // table walk: R1 R4 R5 R6 R7 via bench model
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      check("R4 table g1", sym_g1, m_e1);
      check("R5 table g2", sym_g2, m_e2);
    end

    // R8: idle with moving inputs, outputs hold
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      din = c[0]; long_k_sel = c[1]; diff_en = ~c[0]; g2_inv_en = c[2];
      check("R8 idle g1", sym_g1, m_e1);
      check("R8 idle g2", sym_g2, m_e2);
    end
    // history and differential state untouched: resume matches model
    for (int v = 0; v < 12; v++) begin
      step(v[0] ^ v[2], 1'b1, 1'b1, v[1]);
      check("R8 resume g1", sym_g1, m_e1);
      check("R8 resume g2", sym_g2, m_e2);
    end

    // R2: impulse response, short code, read straight from generator digits
    do_reset();
    for (int j = 0; j < 9; j++) begin
      step(j == 0, 1'b0, 1'b0, 1'b0);
      if (j >= 2) begin
        check("R2 impulse g1", sym_g1, IMP7_G1[6-(j-2)]);
        check("R2 impulse g2", sym_g2, IMP7_G2[6-(j-2)]);
      end else begin
        check("R4 early g1", sym_g1, 1'b0);
        check("R4 early g2", sym_g2, 1'b0);
      end
    end
    // places 7 and 8 hold the impulse but the short code ignores them
    for (int j = 0; j < 2; j++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check("R2 short window g1", sym_g1, 1'b0);
      check("R2 short window g2", sym_g2, 1'b0);
    end

    // R3: impulse response, long code
    do_reset();
    for (int j = 0; j < 11; j++) begin
      step(j == 0, 1'b1, 1'b0, 1'b0);
      if (j >= 2) begin
        check("R3 impulse g1", sym_g1, IMP9_G1[8-(j-2)]);
        check("R3 impulse g2", sym_g2, IMP9_G2[8-(j-2)]);
      end
    end

    // R6: differential impulse becomes a run of ones (first place of G1 tapped in both codes)
    do_reset();
    step(1'b1, 1'b0, 1'b1, 1'b0);
    for (int j = 0; j < 4; j++) step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 diff g1", sym_g1, m_e1);
    check("R6 diff g2", sym_g2, m_e2);
    check("R6 diff run vs plain g1", sym_g1, parity_of(9'b000000111, 9'o171, 7));

    // R7: switch length mid-stream, history kept
    do_reset();
    for (int j = 0; j < 9; j++) step(j[0] ^ j[1], 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 switch g1", sym_g1, m_e1);
    check("R7 switch g2", sym_g2, m_e2);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    check("R7 switch back g1", sym_g1, m_e1);
    check("R5 switch back g2", sym_g2, m_e2);

    // R9: reset in mid-stream clears everything
    for (int j = 0; j < 5; j++) step(1'b1, 1'b1, 1'b1, 1'b1);
    do_reset();
    step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    check("R9 cleared g1", sym_g1, 1'b0);
    check("R9 cleared inverted g2", sym_g2, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule